// File: doc/BRIEF.md
# Port-I/O Instruction Sequencer

This block is the control core of a tiny byte-wide processor. It fetches opcodes from a byte memory and carries out a four-instruction repertoire: load the 16-bit register pair DX from two immediate bytes, read an I/O port into the accumulator low byte AL, write AL to an I/O port, and jump to an absolute address. The memory and the ports share one address bus, one read-data bus and one write-data bus. Three strobes tell them apart: memory read, I/O read and I/O write. The port address of an I/O access is always the value held in DX.

The block keeps a program counter (PC) and a separate memory address register (MAR) that drives the address bus. At decode, the PC moves past the whole instruction in one step, while the MAR walks through the operand bytes one at a time. Every bus access takes two clocks. In the setup clock the address, and for a write also the data, is driven with no strobe. In the strobe clock the strobe is high, and read data is captured at the clock edge that ends it. An opcode outside the repertoire parks the sequencer in a halt state.

States: FETCH_SETUP, FETCH_STROBE, DECODE, OPND_SETUP, OPND_STROBE, IO_SETUP, IO_STROBE, HALT. The transitions are:
- FETCH_SETUP→FETCH_STROBE→DECODE.
- DECODE→OPND_SETUP for load-DX and jump.
- DECODE→IO_SETUP for port read and port write.
- DECODE→HALT for any other opcode.
- OPND_SETUP→OPND_STROBE.
- OPND_STROBE→OPND_SETUP after the first operand byte.
- OPND_STROBE→FETCH_SETUP after the second operand byte.
- IO_SETUP→IO_STROBE→FETCH_SETUP.
- HALT→HALT.

Top module: `portio_seq`

## Requirements
- R1: While reset is low and in the first clock after it, PC, MAR, DX and AL are zero. The address bus reads 0x0000, all strobes and `halted` are low, and the write-data bus is zero. The first fetch comes from address 0x0000.
- R2: A fetch drives the PC value on the address bus for one clock with no strobe, then asserts `mem_rd` for one clock. The byte on `bus_rdata` at the end of that clock becomes the opcode. One decode clock follows with the address unchanged and no strobe.
- R3: The opcodes are 0x01 load-DX (3 bytes), 0x02 port read (1 byte), 0x03 port write (1 byte) and 0x04 jump (3 bytes). Except after a jump, the next fetch address is the previous fetch address plus the instruction length.
- R4: Load-DX reads its operands at fetch address +1 and +2 in that order. The first byte becomes DH (bits 15:8) and the second becomes DL (bits 7:0). This is visible as the address of later port accesses.
- R5: Port read drives DX on the address bus and asserts `io_rd`, never `mem_rd`. `bus_rdata` at the end of the strobe clock is loaded into AL.
- R6: Port write drives DX on the address bus and AL on `bus_wdata` during both its setup and strobe clocks, and asserts `io_wr` in the second clock.
- R7: Jump reads a high byte at fetch address +1 and a low byte at +2. The next fetch comes from the address these two bytes form.
- R8: A port read with no responding device still loads AL with whatever `bus_rdata` carries at the end of the strobe.
- R9: Any other opcode leads, in the clock after decode, to `halted` high for good. From then on there are no strobes, and the address bus holds the address of the offending opcode.
- R10: Each strobe lasts exactly one clock, at most one strobe is high at a time, and the address is the same in the clock before the strobe. `bus_wdata` is zero outside a port write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | output | 16 | Shared address bus (the MAR) |
| bus_wdata | output | 8 | Write data; AL during a port write, else zero |
| bus_rdata | input | 8 | Read data from memory or from the addressed port |
| mem_rd | output | 1 | Memory read strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| halted | output | 1 | High once an unknown opcode has been decoded |

## Verification
The bench carries its own model of the sequencer state and checks every port on every clock. A wrong PC step or a wrong jump target shows on the address bus at the very next fetch setup clock. A swapped DH/DL or a wrong AL capture stays hidden until the next port access, where it appears as the wrong address or as the wrong write data one clock before the strobe. A state machine that skips a setup clock or stretches a strobe is caught in that same clock. A loop that reads a button port and writes an LED port also shows the end-to-end effect over several iterations.

// File: rtl/portio_pkg.sv
package portio_pkg;

    localparam logic [7:0] OP_LDX  = 8'h01;
    localparam logic [7:0] OP_PIN  = 8'h02;
    localparam logic [7:0] OP_POUT = 8'h03;
    localparam logic [7:0] OP_JMP  = 8'h04;

    typedef enum logic [2:0] {
        ST_FETCH_SETUP,
        ST_FETCH_STROBE,
        ST_DECODE,
        ST_OPND_SETUP,
        ST_OPND_STROBE,
        ST_IO_SETUP,
        ST_IO_STROBE,
        ST_HALT
    } seq_state_e;

    typedef enum logic [2:0] {
        MAR_HOLD,
        MAR_STEP,
        MAR_PC,
        MAR_DX,
        MAR_TARGET
    } mar_src_e;

    typedef struct packed {
        logic       ir_load;
        logic       pc_step;
        logic [1:0] pc_len;
        logic       pc_jump;
        mar_src_e   mar_src;
        logic       hi_load;
        logic       dx_load;
        logic       al_load;
        logic       drive_al;
    } dp_ctl_t;

endpackage

// File: rtl/portio_ctrl.sv
module portio_ctrl
    import portio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ir,
    output dp_ctl_t           ctl,
    output logic              mem_rd,
    output logic              io_rd,
    output logic              io_wr,
    output logic              halted
);

    seq_state_e state_q, state_d;
    logic       second_q;

    logic is_ldx, is_pin, is_pout, is_jmp;
    assign is_ldx  = (ir == DATA_W'(OP_LDX));
    assign is_pin  = (ir == DATA_W'(OP_PIN));
    assign is_pout = (ir == DATA_W'(OP_POUT));
    assign is_jmp  = (ir == DATA_W'(OP_JMP));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_FETCH_SETUP;
            second_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_DECODE)
                second_q <= 1'b0;
            else if (state_q == ST_OPND_STROBE)
                second_q <= ~second_q;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH_SETUP:  state_d = ST_FETCH_STROBE;
            ST_FETCH_STROBE: state_d = ST_DECODE;
            ST_DECODE: begin
                if (is_ldx || is_jmp)      state_d = ST_OPND_SETUP;
                else if (is_pin || is_pout) state_d = ST_IO_SETUP;
                else                       state_d = ST_HALT;
            end
            ST_OPND_SETUP:   state_d = ST_OPND_STROBE;
            ST_OPND_STROBE:  state_d = second_q ? ST_FETCH_SETUP : ST_OPND_SETUP;
            ST_IO_SETUP:     state_d = ST_IO_STROBE;
            ST_IO_STROBE:    state_d = ST_FETCH_SETUP;
            ST_HALT:         state_d = ST_HALT;
        endcase
    end

    always_comb begin
        ctl    = '0;
        mem_rd = 1'b0;
        io_rd  = 1'b0;
        io_wr  = 1'b0;
        halted = 1'b0;
        unique case (state_q)
            ST_FETCH_SETUP: ;
            ST_FETCH_STROBE: begin
                mem_rd      = 1'b1;
                ctl.ir_load = 1'b1;
            end
            ST_DECODE: begin
                ctl.pc_step = 1'b1;
                if (is_ldx || is_jmp) begin
                    ctl.pc_len  = 2'd3;
                    ctl.mar_src = MAR_STEP;
                end else if (is_pin || is_pout) begin
                    ctl.pc_len  = 2'd1;
                    ctl.mar_src = MAR_DX;
                end
            end
            ST_OPND_SETUP: ;
            ST_OPND_STROBE: begin
                mem_rd = 1'b1;
                if (!second_q) begin
                    ctl.hi_load = 1'b1;
                    ctl.mar_src = MAR_STEP;
                end else if (is_jmp) begin
                    ctl.pc_jump = 1'b1;
                    ctl.mar_src = MAR_TARGET;
                end else begin
                    ctl.dx_load = 1'b1;
                    ctl.mar_src = MAR_PC;
                end
            end
            ST_IO_SETUP: begin
                ctl.drive_al = is_pout;
            end
            ST_IO_STROBE: begin
                io_rd        = is_pin;
                io_wr        = is_pout;
                ctl.al_load  = is_pin;
                ctl.drive_al = is_pout;
                ctl.mar_src  = MAR_PC;
            end
            ST_HALT: halted = 1'b1;
        endcase
    end

endmodule

// File: rtl/portio_dpath.sv
module portio_dpath
    import portio_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dp_ctl_t           ctl,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ir
);

    logic [ADDR_W-1:0] pc_q, mar_q, dx_q;
    logic [DATA_W-1:0] ir_q, hi_q, al_q;
    logic [ADDR_W-1:0] target;

    assign target = {hi_q, rdata};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            mar_q <= '0;
            dx_q  <= '0;
            ir_q  <= '0;
            hi_q  <= '0;
            al_q  <= '0;
        end else begin
            if (ctl.ir_load) ir_q <= rdata;
            if (ctl.hi_load) hi_q <= rdata;
            if (ctl.dx_load) dx_q <= target;
            if (ctl.al_load) al_q <= rdata;
            if (ctl.pc_jump)
                pc_q <= target;
            else if (ctl.pc_step)
                pc_q <= pc_q + ADDR_W'(ctl.pc_len);
            unique case (ctl.mar_src)
                MAR_STEP:   mar_q <= mar_q + 1'b1;
                MAR_PC:     mar_q <= pc_q;
                MAR_DX:     mar_q <= dx_q;
                MAR_TARGET: mar_q <= target;
                default:    mar_q <= mar_q;
            endcase
        end
    end

    assign addr  = mar_q;
    assign wdata = ctl.drive_al ? al_q : '0;
    assign ir    = ir_q;

endmodule

// File: rtl/portio_seq.sv
module portio_seq
    import portio_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              mem_rd,
    output logic              io_rd,
    output logic              io_wr,
    output logic              halted
);

    dp_ctl_t           ctl;
    logic [DATA_W-1:0] ir;

    portio_ctrl #(.DATA_W(DATA_W)) ctrl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ir     (ir),
        .ctl    (ctl),
        .mem_rd (mem_rd),
        .io_rd  (io_rd),
        .io_wr  (io_wr),
        .halted (halted)
    );

    portio_dpath #(.DATA_W(DATA_W)) dpath_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (ctl),
        .rdata (bus_rdata),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .ir    (ir)
    );

endmodule

// File: rtl/portio_seq_chk.sv
module portio_seq_chk #(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              mem_rd,
    input logic              io_rd,
    input logic              io_wr,
    input logic              halted
);

    logic any_stb;
    assign any_stb = mem_rd | io_rd | io_wr;

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, io_rd, io_wr}));

    // R10
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |=> !any_stb);

    // R10
    addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |-> ($stable(bus_addr) && !$past(any_stb)));

    // R10
    wdata_only_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wdata != '0) && !io_wr) |=> io_wr);

    // R6
    wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr |-> $stable(bus_wdata));

    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !any_stb);

    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(bus_addr)));

endmodule

bind portio_seq portio_seq_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .mem_rd    (mem_rd),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .halted    (halted)
);

// File: tb/portio_seq_tb.sv
module portio_seq_tb_top;

    localparam logic [15:0] LED_PORT = 16'h0378;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        mem_rd, io_rd, io_wr, halted;

    always #4 clk = ~clk;

    portio_seq dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mem_rd    (mem_rd),
        .io_rd     (io_rd),
        .io_wr     (io_wr),
        .halted    (halted)
    );

    logic [7:0] mem [0:255];
    logic       button = 1'b0;
    logic       led_q = 1'b0;

    function automatic logic [7:0] port_value(input logic [15:0] a);
        return (a == LED_PORT) ? {7'b0, button} : 8'hFF;
    endfunction

    always_comb begin
        if (mem_rd)     bus_rdata = mem[bus_addr[7:0]];
        else if (io_rd) bus_rdata = port_value(bus_addr);
        else            bus_rdata = 8'hFF;
    end

    always @(posedge clk)
        if (io_wr && bus_addr == LED_PORT) led_q <= bus_wdata[0];

    typedef struct {
        logic [15:0] a;
        logic        mr, ird, iwr, hl, cap;
        logic [7:0]  wd;
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [15:0] pc_m, dx_m, halt_a;
    logic [7:0]  al_m;
    bit          halted_m;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    task automatic push(input logic [15:0] a, input logic mr, input logic ird,
                        input logic iwr, input logic cap, input logic [7:0] wd,
                        input string tag);
        exp_t e;
        e.a = a; e.mr = mr; e.ird = ird; e.iwr = iwr; e.hl = 1'b0;
        e.cap = cap; e.wd = wd; e.tag = tag;
        q.push_back(e);
    endtask

    function automatic logic [7:0] mbyte(input logic [15:0] a);
        return mem[a[7:0]];
    endfunction

    task automatic gen_instr();
        logic [7:0] op;
        op = mbyte(pc_m);
        push(pc_m, 0, 0, 0, 0, 8'h00, "R1 R3 R10 fetch setup");
        push(pc_m, 1, 0, 0, 0, 8'h00, "R2 fetch strobe");
        push(pc_m, 0, 0, 0, 0, 8'h00, "R2 decode");
        case (op)
            8'h01, 8'h04: begin
                push(pc_m + 16'd1, 0, 0, 0, 0, 8'h00, "R4 R7 R10 operand1 setup");
                push(pc_m + 16'd1, 1, 0, 0, 0, 8'h00, "R4 R7 operand1 strobe");
                push(pc_m + 16'd2, 0, 0, 0, 0, 8'h00, "R4 R7 R10 operand2 setup");
                push(pc_m + 16'd2, 1, 0, 0, 0, 8'h00, "R4 R7 operand2 strobe");
                if (op == 8'h01) begin
                    dx_m = {mbyte(pc_m + 16'd1), mbyte(pc_m + 16'd2)};
                    pc_m = pc_m + 16'd3;
                end else begin
                    pc_m = {mbyte(pc_m + 16'd1), mbyte(pc_m + 16'd2)};
                end
            end
            8'h02: begin
                push(dx_m, 0, 0, 0, 0, 8'h00, "R5 R10 port read setup");
                push(dx_m, 0, 1, 0, 1, 8'h00, "R5 R8 port read strobe");
                pc_m = pc_m + 16'd1;
            end
            8'h03: begin
                push(dx_m, 0, 0, 0, 0, al_m, "R6 R10 port write setup");
                push(dx_m, 0, 0, 1, 0, al_m, "R6 port write strobe");
                pc_m = pc_m + 16'd1;
            end
            default: begin
                halted_m = 1'b1;
                halt_a   = pc_m;
            end
        endcase
    endtask

    task automatic check_cycle();
        exp_t e;
        if (q.size() == 0 && !halted_m) gen_instr();
        if (q.size() == 0) begin
            e.a = halt_a; e.mr = 0; e.ird = 0; e.iwr = 0; e.hl = 1'b1;
            e.cap = 0; e.wd = 8'h00; e.tag = "R9 halted";
        end else begin
            e = q.pop_front();
        end
        if (e.cap) al_m = port_value(e.a);
        checks++;
        if (bus_addr !== e.a || mem_rd !== e.mr || io_rd !== e.ird || io_wr !== e.iwr ||
            bus_wdata !== e.wd || halted !== e.hl) begin
            errors++;
            $display("FAIL %s: got addr=%h mr=%b ir=%b iw=%b wd=%h hlt=%b expected addr=%h mr=%b ir=%b iw=%b wd=%h hlt=%b",
                     e.tag, bus_addr, mem_rd, io_rd, io_wr, bus_wdata, halted,
                     e.a, e.mr, e.ird, e.iwr, e.wd, e.hl);
        end
    endtask

    task automatic model_reset();
        q.delete();
        pc_m = '0; dx_m = '0; al_m = '0; halted_m = 1'b0; halt_a = '0;
    endtask

    task automatic check_reset();
        checks++;
        if (bus_addr !== 16'h0000 || mem_rd !== 1'b0 || io_rd !== 1'b0 || io_wr !== 1'b0 ||
            halted !== 1'b0 || bus_wdata !== 8'h00) begin
            errors++;
            $display("FAIL R1: got addr=%h mr=%b ir=%b iw=%b hlt=%b wd=%h expected 0000 0 0 0 0 00",
                     bus_addr, mem_rd, io_rd, io_wr, halted, bus_wdata);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got run still active expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        bit   pend;
        logic pend_val, btn_seen;
        int   led_on, led_off;
        pend = 0; pend_val = 0; btn_seen = 0; led_on = 0; led_off = 0;

        // Phase 1: LDX 0x0378 ; IN ; OUT ; JMP 0x0003
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mem[0] = 8'h01; mem[1] = 8'h03; mem[2] = 8'h78;
        mem[3] = 8'h02; mem[4] = 8'h03;
        mem[5] = 8'h04; mem[6] = 8'h00; mem[7] = 8'h03;
        model_reset();
        repeat (3) @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 600; cyc++) begin
            if (cyc % 37 == 36) button = ~button;
            if (pend) begin
                pend = 0;
                checks++;
                if (led_q !== pend_val) begin
                    errors++;
                    $display("FAIL R6 led: got %b expected %b", led_q, pend_val);
                end
                if (led_q) led_on++; else led_off++;
            end
            if (io_rd) btn_seen = button;
            if (io_wr && bus_addr == LED_PORT) begin
                pend = 1; pend_val = btn_seen;
            end
            check_cycle();
            @(negedge clk);
        end
        checks++;
        if (led_on == 0 || led_off == 0) begin
            errors++;
            $display("FAIL R6 led coverage: got on=%0d off=%0d expected both nonzero", led_on, led_off);
        end

        // Phase 2: LDX 0x1234 ; OUT ; IN (no device) ; OUT ; JMP 0x0040 ; bad opcode
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mem[0] = 8'h01; mem[1] = 8'h12; mem[2] = 8'h34;
        mem[3] = 8'h03; mem[4] = 8'h02; mem[5] = 8'h03;
        mem[6] = 8'h04; mem[7] = 8'h00; mem[8] = 8'h40;
        mem[8'h40] = 8'hA5;
        model_reset();
        repeat (2) @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 80; cyc++) begin
            check_cycle();
            @(negedge clk);
        end
        checks++;
        if (halted !== 1'b1) begin
            errors++;
            $display("FAIL R9 final: got halted=%b expected 1", halted);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule